// File: doc/BRIEF.md
# Microcontroller sleep mode controller

This block manages low-power states for a small 8-bit processor core. Software writes an 8-bit control register that holds a sleep-enable flag and a two-bit mode selector. When the core reports that it has executed a sleep instruction and the enable flag is set, the controller moves into Idle, Power-down or Standby. It then drives one clock-enable output for each of five domains: CPU, flash, I/O, asynchronous logic and oscillator.

While asleep, the controller watches the wake sources that the current mode allows. When a wake is accepted, it keeps the core halted for a start-up delay that depends on the mode, plus four fixed cycles. It then signals the core to service the interrupt and to resume after the sleep instruction. A reset request that arrives during sleep or during waking skips this sequence. The controller returns to the awake state on the next edge and signals a restart from the reset vector.

The controller has no path to the register file or to data memory, so sleeping cannot alter either of them.

Top module: `slp_ctrl`

## Requirements
- R1: The control register resets to 0x00. A write stores all 8 bits, and the read port returns the stored value. Bit 6 is the mode-select high bit, bit 5 is sleep enable and bit 4 is the mode-select low bit. The other bits are plain storage.
- R2: A sleep request while the sleep-enable bit is 0 has no effect. The state stays awake (code 0) and all five clock enables stay at 1.
- R3: A sleep request with sleep enable set enters a state that the mode bits {bit6,bit4} select on the next edge. The mapping is 00 to Idle (code 1), 01 to Power-down (code 2), 10 to Standby (code 3) and 11 to Power-down (code 2).
- R4: Clock enables are indexed 0 CPU, 1 flash, 2 I/O, 3 async and 4 oscillator. In Idle they read 5'b11100, and in waking (code 4) they also read 5'b11100.
- R5: Power-down drives all clock enables to 0. Standby drives 5'b10000, which keeps only the oscillator enabled.
- R6: In Idle, either the external or the internal wake input starts waking. In Power-down and Standby, only the external wake input does, and the internal input leaves the state unchanged.
- R7: After a wake is accepted, the waking state lasts D+4 cycles. D is IDLE_DLY, PDWN_DLY or STBY_DLY for the mode that was left. resume_irq_o is high only in the last waking cycle, and the state is awake on the following cycle.
- R8: While the state is not awake, a high rst_req_i makes resume_rst_o high in that cycle and keeps resume_irq_o low. The state returns to awake on the next edge.
- R9: core_halt_o is high exactly when the state is not awake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 8 | Control register write data |
| reg_rdata_o | output | 8 | Control register read data |
| sleep_req_i | input | 1 | Core executed a sleep instruction (one cycle) |
| ext_wake_i | input | 1 | External or asynchronous wake request (pin interrupt, watchdog) |
| int_wake_i | input | 1 | Internal interrupt wake request (timer, serial) |
| rst_req_i | input | 1 | Reset request seen during sleep |
| clk_en_o | output | 5 | Per-domain clock enables: CPU, flash, I/O, async, oscillator |
| core_halt_o | output | 1 | Core must stay stalled |
| resume_irq_o | output | 1 | Wake complete, service the interrupt |
| resume_rst_o | output | 1 | Leave sleep and restart from the reset vector |
| state_o | output | 3 | 0 awake, 1 idle, 2 power-down, 3 standby, 4 waking |

## Verification
The assertions assume that sleep_req_i and the wake inputs are synchronous to clk_i and that rst_req_i is a level which overrides wake inputs in the same cycle. They also assume that the register is not written in the cycle the sleep request arrives, so the mode the checker decodes from reg_rdata_o is the one the FSM used. The stimulus drives every input one time unit after a rising edge. It never overlaps a register write with a sleep request, and it clears each wake or reset pulse before the next step starts.

// File: rtl/slp_pkg.sv
package slp_pkg;
  typedef enum logic [2:0] {
    ST_AWAKE = 3'd0,
    ST_IDLE  = 3'd1,
    ST_PDWN  = 3'd2,
    ST_STBY  = 3'd3,
    ST_WAKE  = 3'd4
  } slp_state_e;

  localparam int NUM_DOM   = 5;
  localparam int DOM_CPU   = 0;
  localparam int DOM_FLASH = 1;
  localparam int DOM_IO    = 2;
  localparam int DOM_ASYNC = 3;
  localparam int DOM_OSC   = 4;

  localparam int REG_W     = 8;
  localparam int SM_HI_BIT = 6;
  localparam int SE_BIT    = 5;
  localparam int SM_LO_BIT = 4;
endpackage

// File: rtl/slp_ctrl_reg.sv
module slp_ctrl_reg #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= wdata_i;
  end
endmodule

// File: rtl/slp_clk_dec.sv
module slp_clk_dec
  import slp_pkg::*;
(
  input  slp_state_e         state_i,
  output logic [NUM_DOM-1:0] clk_en_o
);
  logic core_on, periph_on, osc_on;

  always_comb begin
    core_on   = (state_i == ST_AWAKE);
    periph_on = (state_i == ST_AWAKE) || (state_i == ST_IDLE) || (state_i == ST_WAKE);
    osc_on    = periph_on || (state_i == ST_STBY);
  end

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    if (d == DOM_CPU || d == DOM_FLASH) begin : g_core
      assign clk_en_o[d] = core_on;
    end else if (d == DOM_OSC) begin : g_osc
      assign clk_en_o[d] = osc_on;
    end else begin : g_periph
      assign clk_en_o[d] = periph_on;
    end
  end
endmodule

// File: rtl/slp_wake_timer.sv
module slp_wake_timer #(
  parameter int CW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          run_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (load_i)                   cnt_q <= load_val_i;
    else if (run_i && cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/slp_ctrl.sv
module slp_ctrl
  import slp_pkg::*;
#(
  parameter int IDLE_DLY = 0,
  parameter int PDWN_DLY = 16,
  parameter int STBY_DLY = 6,
  parameter int HALT_CYC = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [REG_W-1:0]   reg_wdata_i,
  output logic [REG_W-1:0]   reg_rdata_o,
  input  logic               sleep_req_i,
  input  logic               ext_wake_i,
  input  logic               int_wake_i,
  input  logic               rst_req_i,
  output logic [NUM_DOM-1:0] clk_en_o,
  output logic               core_halt_o,
  output logic               resume_irq_o,
  output logic               resume_rst_o,
  output logic [2:0]         state_o
);
  localparam int MAX_DLY = (PDWN_DLY > STBY_DLY) ?
                           ((PDWN_DLY > IDLE_DLY) ? PDWN_DLY : IDLE_DLY) :
                           ((STBY_DLY > IDLE_DLY) ? STBY_DLY : IDLE_DLY);
  localparam int CW = $clog2(MAX_DLY + HALT_CYC + 1);

  slp_state_e    state_q, state_d;
  logic [REG_W-1:0] ctrl_q;
  logic          sleep_en;
  logic [1:0]    mode_sel;
  slp_state_e    tgt_state;
  logic          asleep, wake_ok, tmr_load, tmr_zero;
  logic [CW-1:0] tmr_val;

  slp_ctrl_reg #(.DW(REG_W)) u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .wdata_i (reg_wdata_i),
    .q_o     (ctrl_q)
  );

  assign reg_rdata_o = ctrl_q;
  assign sleep_en    = ctrl_q[SE_BIT];
  assign mode_sel    = {ctrl_q[SM_HI_BIT], ctrl_q[SM_LO_BIT]};

  always_comb begin
    unique case (mode_sel)
      2'b00:   tgt_state = ST_IDLE;
      2'b10:   tgt_state = ST_STBY;
      default: tgt_state = ST_PDWN;  // 01 and 11 both power-down
    endcase
  end

  assign asleep  = (state_q == ST_IDLE) || (state_q == ST_PDWN) || (state_q == ST_STBY);
  assign wake_ok = ext_wake_i || (int_wake_i && state_q == ST_IDLE);
  assign tmr_load = asleep && wake_ok && !rst_req_i;

  // count value includes start-up delay and fixed halt, minus the loading cycle
  always_comb begin
    unique case (state_q)
      ST_PDWN: tmr_val = CW'(PDWN_DLY + HALT_CYC - 1);
      ST_STBY: tmr_val = CW'(STBY_DLY + HALT_CYC - 1);
      default: tmr_val = CW'(IDLE_DLY + HALT_CYC - 1);
    endcase
  end

  slp_wake_timer #(.CW(CW)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .run_i      (state_q == ST_WAKE),
    .zero_o     (tmr_zero)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_AWAKE: if (sleep_req_i && sleep_en) state_d = tgt_state;
      ST_WAKE: begin
        if (rst_req_i || tmr_zero) state_d = ST_AWAKE;
      end
      default: begin
        if (rst_req_i)    state_d = ST_AWAKE;
        else if (wake_ok) state_d = ST_WAKE;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_AWAKE;
    else         state_q <= state_d;
  end

  slp_clk_dec u_dec (
    .state_i  (state_q),
    .clk_en_o (clk_en_o)
  );

  assign core_halt_o  = (state_q != ST_AWAKE);
  assign resume_rst_o = core_halt_o && rst_req_i;
  assign resume_irq_o = (state_q == ST_WAKE) && tmr_zero && !rst_req_i;
  assign state_o      = state_q;
endmodule

// File: rtl/slp_ctrl_chk.sv
module slp_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sleep_req_i,
  input logic       ext_wake_i,
  input logic       rst_req_i,
  input logic [7:0] reg_rdata_o,
  input logic [4:0] clk_en_o,
  input logic       core_halt_o,
  input logic       resume_irq_o,
  input logic       resume_rst_o,
  input logic [2:0] state_o
);
  p_no_sleep_wo_se_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd0 && sleep_req_i && !reg_rdata_o[5]) |=> state_o == 3'd0);

  p_stby_entry_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd0 && sleep_req_i && reg_rdata_o[6:4] == 3'b110) |=> state_o == 3'd3);

  p_pdwn_alias_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd0 && sleep_req_i && reg_rdata_o[5] && reg_rdata_o[4]) |=> state_o == 3'd2);

  p_idle_clk_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 3'd1 |-> clk_en_o == 5'b11100);

  p_pdwn_clk_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 3'd2 |-> clk_en_o == 5'b00000);

  p_stby_clk_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 3'd3 |-> clk_en_o == 5'b10000);

  p_int_ignored_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_o == 3'd2 || state_o == 3'd3) && !ext_wake_i && !rst_req_i) |=> $stable(state_o));

  p_irq_exit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_irq_o |=> state_o == 3'd0);

  p_rst_exit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o != 3'd0 && rst_req_i) |=> state_o == 3'd0);

  p_rst_no_irq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_rst_o |-> !resume_irq_o);

  p_halt_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_halt_o |-> clk_en_o[0] == 1'b0);
endmodule

bind slp_ctrl slp_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sleep_req_i  (sleep_req_i),
  .ext_wake_i   (ext_wake_i),
  .rst_req_i    (rst_req_i),
  .reg_rdata_o  (reg_rdata_o),
  .clk_en_o     (clk_en_o),
  .core_halt_o  (core_halt_o),
  .resume_irq_o (resume_irq_o),
  .resume_rst_o (resume_rst_o),
  .state_o      (state_o)
);

// File: tb/slp_ctrl_bench.sv
module slp_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int IDLE_D = 0;
  localparam int PDWN_D = 16;
  localparam int STBY_D = 6;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       reg_we_i = 1'b0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic       sleep_req_i = 1'b0;
  logic       ext_wake_i = 1'b0;
  logic       int_wake_i = 1'b0;
  logic       rst_req_i = 1'b0;
  logic [4:0] clk_en_o;
  logic       core_halt_o, resume_irq_o, resume_rst_o;
  logic [2:0] state_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  slp_ctrl #(.IDLE_DLY(IDLE_D), .PDWN_DLY(PDWN_D), .STBY_DLY(STBY_D), .HALT_CYC(4)) u_slp_ctrl (
    .clk_i, .rst_ni, .reg_we_i, .reg_wdata_i, .reg_rdata_o, .sleep_req_i,
    .ext_wake_i, .int_wake_i, .rst_req_i, .clk_en_o, .core_halt_o,
    .resume_irq_o, .resume_rst_o, .state_o
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  function automatic int exp_state(input int m);
    return (m == 0) ? 1 : (m == 2) ? 3 : 2;
  endfunction

  function automatic int exp_clk(input int st);
    return (st == 1) ? 5'b11100 : (st == 3) ? 5'b10000 : 0;
  endfunction

  function automatic int exp_dly(input int st);
    return (st == 1) ? IDLE_D : (st == 3) ? STBY_D : PDWN_D;
  endfunction

  task automatic wr(input logic [7:0] v);
    reg_we_i = 1'b1; reg_wdata_i = v;
    tick();
    reg_we_i = 1'b0;
  endtask

  task automatic go_sleep(input int m, input bit se);
    wr({1'b0, m[1], se, m[0], 4'h0});
    sleep_req_i = 1'b1;
    tick();
    sleep_req_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*2);
    #1;
    chk("R1 reset value", reg_rdata_o, 0);
    chk("R9 reset awake", state_o, 0);
    chk("R9 reset halt", core_halt_o, 0);
    rst_ni = 1'b1;
    tick();

    // R1 register storage
    for (int i = 0; i < 256; i += 37) begin
      wr(8'(i * 7 + 3));
      chk("R1 readback", reg_rdata_o, (i * 7 + 3) % 256);
      chk("R1 no sleep from write", state_o, 0);
    end

    for (int m = 0; m < 4; m++) begin
      int st;
      int n;
      int irq_at;
      st = exp_state(m);

      // R2: enable bit clear
      go_sleep(m, 1'b0);
      chk("R2 state", state_o, 0);
      chk("R2 clk_en", clk_en_o, 5'h1f);
      tick();
      chk("R2 state later", state_o, 0);

      // R3/R4/R5/R9 entry
      go_sleep(m, 1'b1);
      chk("R3 mode decode", state_o, st);
      chk("R4/R5 clk_en", clk_en_o, exp_clk(st));
      chk("R9 halt asleep", core_halt_o, 1);

      // R6 internal wake
      int_wake_i = 1'b1;
      tick();
      int_wake_i = 1'b0;
      if (st == 1) begin
        chk("R6 idle int wake", state_o, 4);
      end else begin
        chk("R6 int ignored", state_o, st);
        chk("R6 int ignored clk", clk_en_o, exp_clk(st));
        tick();
        chk("R6 still asleep", state_o, st);
        ext_wake_i = 1'b1;
        tick();
        ext_wake_i = 1'b0;
        chk("R6 ext wake", state_o, 4);
      end

      // R7 wake timing
      chk("R4 waking clk_en", clk_en_o, 5'b11100);
      n = 0; irq_at = -1;
      while (state_o == 3'd4 && n < 100) begin
        if (resume_irq_o) irq_at = n;
        n++;
        tick();
      end
      chk("R7 waking length", n, exp_dly(st) + 4);
      chk("R7 irq last cycle", irq_at, exp_dly(st) + 3);
      chk("R7 awake after", state_o, 0);
      chk("R9 halt released", core_halt_o, 0);
      chk("R7 clocks restored", clk_en_o, 5'h1f);

      // R8 reset during sleep
      go_sleep(m, 1'b1);
      rst_req_i = 1'b1;
      #1;
      chk("R8 rst signal", resume_rst_o, 1);
      chk("R8 no irq", resume_irq_o, 0);
      tick();
      rst_req_i = 1'b0;
      chk("R8 exit sleep", state_o, 0);
      chk("R8 rst cleared", resume_rst_o, 0);

      // R8 reset during waking, from external wake
      go_sleep(m, 1'b1);
      ext_wake_i = 1'b1;
      tick();
      ext_wake_i = 1'b0;
      chk("R6 ext wake any mode", state_o, 4);
      tick();
      rst_req_i = 1'b1;
      #1;
      chk("R8 rst in waking", resume_rst_o, 1);
      chk("R8 no irq in waking", resume_irq_o, 0);
      tick();
      rst_req_i = 1'b0;
      chk("R8 exit waking", state_o, 0);
      tick();
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule